// File: doc/BRIEF.md
# Read-Address Unlock Sequence Detector

This block watches the access stream of a byte-wide memory and picks out a fixed chain of six consecutive read cycles. The first five addresses act as an unlock prefix. The sixth address selects the command. One value requests a copy of the working array into nonvolatile cells (store), and a neighbouring value requests the reverse copy (recall). The request goes out as a single-cycle pulse to a separate transfer controller. Any write, or any read that does not match the next expected address, breaks the chain. The detector then flags an abort and returns to idle.

An access is counted once, on the clock cycle where the active-low chip enable is first seen low. The output-enable level plays no part in the sequence and is not an input. While the transfer controller reports busy, the detector ignores every access and keeps its progress. A memory that uses the detector blocks its data pins from the moment a command is accepted until the busy indication from the transfer controller drops.

Top module: `unlock_seq_detect`

## Requirements
- R1: The prefix must be read in this exact order: 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0. Each prefix read produces no request and no abort.
- R2: After the full prefix, a read of 0x0F0F raises `storeReq` high for exactly one clock. The pulse comes in the cycle after the clock edge that sampled the chip-enable falling edge. `recallReq` stays low.
- R3: After the full prefix, a read of 0x0F0E raises `recallReq` high for exactly one clock, with the same timing as R2. `storeReq` stays low.
- R4: A write access (`writeEnN` low) never advances the sequence. While a sequence is in progress, a write pulses `seqAbort` for one clock and returns the detector to idle. A write to 0x0000 does not start a sequence.
- R5: While a sequence is in progress, a read whose address is not the next expected one pulses `seqAbort` and returns the detector to idle, with no request. This includes a sixth address other than the two command values. An unmatched access while idle raises no abort.
- R6: When a read of 0x0000 causes an abort, it also counts as the first step of a new sequence.
- R7: An access is counted only on the high-to-low transition of `chipEnN`. Holding `chipEnN` low for further cycles adds no further access. With no access, all three pulse outputs stay low.
- R8: While `xferBusy` is high, accesses are ignored: no request, no abort, and no change to the sequence progress.
- R9: `ioHold` goes high in the same cycle as a store or recall request. It stays high until the cycle after `xferBusy` falls from high to low.
- R10: After reset, all outputs are low and the detector is idle.
- R11: At most one of `storeReq`, `recallReq` and `seqAbort` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| chipEnN | input | 1 | Active-low chip enable; its falling edge marks an access |
| addr | input | 13 | Access address |
| writeEnN | input | 1 | Active-low write enable; high means a read |
| xferBusy | input | 1 | Transfer controller busy; accesses are ignored while high |
| storeReq | output | 1 | One-cycle store command pulse |
| recallReq | output | 1 | One-cycle recall command pulse |
| seqAbort | output | 1 | One-cycle pulse when a sequence in progress is broken |
| ioHold | output | 1 | Data pins blocked from command acceptance until busy falls |

## Verification
The bench aims at the points where a detector can lose its place. A chip enable held low is one: a design that counts levels instead of edges would count the held access again and abort. A read of 0x0000 that breaks a sequence is another: a design that drops it would not then finish the following five reads with a store. Sixth addresses one bit away from a command value must abort and never raise either request. Accesses during busy must not be counted, must not abort, and must not erase earlier progress. A write in mid-sequence must abort, even when its address matches the expected one. The bench also checks that `ioHold` clears only once busy falls, not when the request pulse ends.

// File: rtl/unlock_seq_pkg.sv
package unlock_seq_pkg;
  localparam int ADDR_W = 13;
  localparam int PREFIX_LEN = 5;
  localparam int STEP_W = $clog2(PREFIX_LEN + 1);
  localparam logic [ADDR_W-1:0] CMD_STORE = 13'h0F0F;
  localparam logic [ADDR_W-1:0] CMD_RECALL = 13'h0F0E;

  function automatic logic [ADDR_W-1:0] prefixAddr(input int idx);
    case (idx)
      0: prefixAddr = 13'h0000;
      1: prefixAddr = 13'h1555;
      2: prefixAddr = 13'h0AAA;
      3: prefixAddr = 13'h1FFF;
      default: prefixAddr = 13'h10F0;
    endcase
  endfunction

  typedef struct packed {
    logic strobe;
    logic isRead;
    logic [PREFIX_LEN-1:0] hitPrefix;
    logic hitStore;
    logic hitRecall;
  } accInfo_t;

  typedef struct packed {
    logic fireStore;
    logic fireRecall;
    logic fireAbort;
  } seqStrobe_t;
endpackage

// File: rtl/unlock_seq_dp.sv
module unlock_seq_dp
  import unlock_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEnN,
  input  logic              xferBusy,
  input  seqStrobe_t        ctrlStrobe,
  output accInfo_t          accInfo,
  output logic              storeReq,
  output logic              recallReq,
  output logic              seqAbort,
  output logic              ioHold
);
  logic ceQ;
  logic busyQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ   <= 1'b1;
      busyQ <= 1'b0;
    end else begin
      ceQ   <= chipEnN;
      busyQ <= xferBusy;
    end
  end

  assign accInfo.strobe    = ceQ & ~chipEnN;
  assign accInfo.isRead    = writeEnN;
  assign accInfo.hitStore  = (addr == CMD_STORE);
  assign accInfo.hitRecall = (addr == CMD_RECALL);

  for (genvar k = 0; k < PREFIX_LEN; k++) begin : g_cmp
    assign accInfo.hitPrefix[k] = (addr == prefixAddr(k));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      storeReq  <= 1'b0;
      recallReq <= 1'b0;
      seqAbort  <= 1'b0;
      ioHold    <= 1'b0;
    end else begin
      storeReq  <= ctrlStrobe.fireStore;
      recallReq <= ctrlStrobe.fireRecall;
      seqAbort  <= ctrlStrobe.fireAbort;
      if (ctrlStrobe.fireStore || ctrlStrobe.fireRecall)
        ioHold <= 1'b1;
      else if (busyQ && !xferBusy)
        ioHold <= 1'b0;
    end
  end

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storeReq, recallReq, seqAbort})); // R11
  AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    storeReq |=> !storeReq); // R2
  AST_RECALL_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    recallReq |=> !recallReq); // R3
  AST_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (accInfo.strobe && !writeEnN) |=> !(storeReq || recallReq)); // R4
  AST_NO_EDGE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !accInfo.strobe |=> !(storeReq || recallReq || seqAbort)); // R7
  AST_HOLD_WITH_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (storeReq || recallReq) |-> ioHold); // R9
endmodule

// File: rtl/unlock_seq_ctrl.sv
module unlock_seq_ctrl
  import unlock_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       xferBusy,
  input  accInfo_t   accInfo,
  output seqStrobe_t ctrlStrobe
);
  logic [STEP_W-1:0]     step;
  logic [STEP_W-1:0]     nextStep;
  logic [PREFIX_LEN-1:0] stepMask;
  logic                  hitCur;
  logic                  readZero;

  assign stepMask = PREFIX_LEN'(1) << step;
  assign hitCur   = |(accInfo.hitPrefix & stepMask);
  assign readZero = accInfo.isRead && accInfo.hitPrefix[0];

  always_comb begin
    ctrlStrobe = '0;
    nextStep   = step;
    if (accInfo.strobe && !xferBusy) begin
      if (step == STEP_W'(PREFIX_LEN)) begin
        nextStep = '0;
        if (accInfo.isRead && accInfo.hitStore)
          ctrlStrobe.fireStore = 1'b1;
        else if (accInfo.isRead && accInfo.hitRecall)
          ctrlStrobe.fireRecall = 1'b1;
        else begin
          ctrlStrobe.fireAbort = 1'b1;
          if (readZero) nextStep = STEP_W'(1);
        end
      end else if (accInfo.isRead && hitCur) begin
        nextStep = step + STEP_W'(1);
      end else begin
        ctrlStrobe.fireAbort = (step != '0);
        nextStep = readZero ? STEP_W'(1) : '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) step <= '0;
    else       step <= nextStep;
  end

  AST_BUSY_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    xferBusy |=> step == $past(step)); // R8
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    step <= STEP_W'(PREFIX_LEN)); // R1
  AST_ABORT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    ctrlStrobe.fireAbort |=> (step == '0 || step == STEP_W'(1))); // R6
endmodule

// File: rtl/unlock_seq_detect.sv
module unlock_seq_detect
  import unlock_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipEnN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              writeEnN,
  input  logic              xferBusy,
  output logic              storeReq,
  output logic              recallReq,
  output logic              seqAbort,
  output logic              ioHold
);
  accInfo_t   accInfo;
  seqStrobe_t ctrlStrobe;

  unlock_seq_dp u_dp (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .addr(addr),
    .writeEnN(writeEnN), .xferBusy(xferBusy), .ctrlStrobe(ctrlStrobe),
    .accInfo(accInfo), .storeReq(storeReq), .recallReq(recallReq),
    .seqAbort(seqAbort), .ioHold(ioHold)
  );

  unlock_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .xferBusy(xferBusy),
    .accInfo(accInfo), .ctrlStrobe(ctrlStrobe)
  );
endmodule

// File: tb/tb_unlock_seq_detect.sv
module tb_unlock_seq_detect;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic chipEnN = 1'b1;
  logic [12:0] addr = '0;
  logic writeEnN = 1'b1;
  logic xferBusy = 1'b0;
  logic storeReq, recallReq, seqAbort, ioHold;
  int nRun = 0;
  int nFail = 0;
  bit finished = 0;
  logic sStore, sRecall, sAbort, sHold;

  always #2 clk = ~clk;

  unlock_seq_detect dut (
    .clk(clk), .rstN(rstN), .chipEnN(chipEnN), .addr(addr),
    .writeEnN(writeEnN), .xferBusy(xferBusy), .storeReq(storeReq),
    .recallReq(recallReq), .seqAbort(seqAbort), .ioHold(ioHold)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [12:0] a, input logic wr, input int holdCycles = 1);
    @(negedge clk);
    addr = a; writeEnN = ~wr; chipEnN = 1'b0;
    @(negedge clk);
    sStore = storeReq; sRecall = recallReq; sAbort = seqAbort; sHold = ioHold;
    for (int i = 1; i < holdCycles; i++) begin
      @(negedge clk);
      chk("R7 held low no abort", seqAbort, 1'b0);
    end
    chipEnN = 1'b1; writeEnN = 1'b1;
  endtask

  task automatic prefix(input int upTo);
    logic [12:0] seqA [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    for (int i = 0; i < upTo; i++) begin
      access(seqA[i], 1'b0);
      chk("R1 prefix quiet", {sStore, sRecall, sAbort}, 3'b000);
    end
  endtask

  task automatic busyPulse();
    @(negedge clk); xferBusy = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 hold while busy", ioHold, 1'b1);
    xferBusy = 1'b0;
    @(negedge clk);
    chk("R9 hold clears after busy falls", ioHold, 1'b0);
  endtask

  task automatic t_reset();
    chk("R10 reset outputs", {storeReq, recallReq, seqAbort, ioHold}, 4'b0000);
  endtask

  task automatic t_store();
    prefix(5);
    access(13'h0F0F, 1'b0);
    chk("R2 store pulse", {sStore, sRecall, sAbort}, 3'b100);
    chk("R9 hold set with store", sHold, 1'b1);
    @(negedge clk);
    chk("R2 store one cycle", storeReq, 1'b0);
    busyPulse();
  endtask

  task automatic t_recall();
    prefix(5);
    access(13'h0F0E, 1'b0);
    chk("R3 recall pulse", {sStore, sRecall, sAbort}, 3'b010);
    @(negedge clk);
    chk("R3 recall one cycle", recallReq, 1'b0);
    busyPulse();
  endtask

  task automatic t_write();
    access(13'h0000, 1'b1);
    chk("R4 write idle quiet", sAbort, 1'b0);
    access(13'h1555, 1'b0);
    chk("R4 write 0000 does not start", sAbort, 1'b0);
    prefix(3);
    access(13'h1FFF, 1'b1);
    chk("R4 write aborts", {sStore, sRecall, sAbort}, 3'b001);
    access(13'h10F0, 1'b0);
    access(13'h0F0F, 1'b0);
    chk("R4 no store after write abort", {sStore, sRecall, sAbort}, 3'b000);
    prefix(5);
    access(13'h0F0F, 1'b1);
    chk("R4 write as sixth aborts", {sStore, sRecall, sAbort}, 3'b001);
  endtask

  task automatic t_order();
    access(13'h0000, 1'b0);
    access(13'h0AAA, 1'b0);
    chk("R5 out of order abort", {sStore, sRecall, sAbort}, 3'b001);
    prefix(5);
    access(13'h0F0D, 1'b0);
    chk("R5 bad sixth abort", {sStore, sRecall, sAbort}, 3'b001);
    access(13'h1234, 1'b0);
    chk("R5 idle mismatch quiet", sAbort, 1'b0);
  endtask

  task automatic t_restart();
    prefix(2);
    access(13'h0000, 1'b0);
    chk("R6 zero read aborts", sAbort, 1'b1);
    access(13'h1555, 1'b0);
    access(13'h0AAA, 1'b0);
    access(13'h1FFF, 1'b0);
    access(13'h10F0, 1'b0);
    chk("R6 restart continues", sAbort, 1'b0);
    access(13'h0F0F, 1'b0);
    chk("R6 store after restart", sStore, 1'b1);
    busyPulse();
  endtask

  task automatic t_held();
    access(13'h0000, 1'b0);
    access(13'h1555, 1'b0, 4);
    access(13'h0AAA, 1'b0);
    access(13'h1FFF, 1'b0);
    access(13'h10F0, 1'b0);
    access(13'h0F0E, 1'b0);
    chk("R7 held access counted once", {sStore, sRecall, sAbort}, 3'b010);
    busyPulse();
  endtask

  task automatic t_busy();
    prefix(3);
    @(negedge clk); xferBusy = 1'b1;
    access(13'h1234, 1'b0);
    chk("R8 busy no abort", {sStore, sRecall, sAbort}, 3'b000);
    access(13'h0000, 1'b1);
    chk("R8 busy write ignored", sAbort, 1'b0);
    @(negedge clk); xferBusy = 1'b0;
    @(negedge clk);
    access(13'h1FFF, 1'b0);
    access(13'h10F0, 1'b0);
    access(13'h0F0E, 1'b0);
    chk("R8 progress kept over busy", {sStore, sRecall, sAbort}, 3'b010);
    busyPulse();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_store();
    t_recall();
    t_write();
    t_order();
    t_restart();
    t_held();
    t_busy();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nRun++; nFail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule